// File: doc/BRIEF.md
# Wish Branch Fetch Mode Controller

This block sits in a processor front end beside the direction predictor and the confidence table. For every fetched branch it takes the branch's 2-bit hint class, the predictor's direction and a one-bit confidence estimate. From these it produces the final predicted direction, an optional speculative value for the branch's source predicate, and the mode the branch was handled in. High-confidence mode behaves like ordinary branch prediction. Low-confidence mode falls back to predicated execution: the branch is steered down the fall-through path and dependents wait for the real predicate.

A wish jump opens a region whose confidence is remembered. Any low-confidence decision inside the region, whether on the jump or on a later join, makes every following join in that region low-confidence as well. A separate loop state tracks wish loops. It remembers the mode the loop was entered in and whether the front end has already left the loop. When the back end resolves a branch, the block decides whether a pipeline flush is needed or whether the wrong-path work can simply drain as no-ops.

Top module: `wishModeCtl`

## Requirements
- R1: The hint field `fetchHint` codes the branch kind as 0 = normal branch, 1 = wish jump, 2 = wish join and 3 = wish loop. A normal branch always takes the predictor's direction, carries no predicate prediction, and reports high-confidence mode (`outModeLow` = 0).
- R2: A wish jump fetched with high confidence reports high mode and takes the predictor's direction. It supplies a valid predicted predicate equal to that direction: true when taken, false when not taken.
- R3: A wish jump fetched with low confidence reports low mode and is predicted not taken, with no predicate prediction.
- R4: After a high-confidence wish jump predicted not taken, the first wish join of the region is predicted taken regardless of the predictor, provided that join is itself high confidence. Joins after the first are not forced.
- R5: A wish join is predicted not taken and reports low mode if the opening jump, any earlier join in the region, or the join itself had low confidence. Otherwise it uses the predictor's direction in high mode. A join never supplies a predicted predicate.
- R6: A resolved misprediction of a wish jump or join raises `flushReq` when the region is in high-confidence mode. It raises no flush when the region is in low-confidence mode.
- R7: A resolved misprediction of a normal branch always raises `flushReq`.
- R8: A wish loop takes its mode from the confidence at its first fetch and keeps that mode until the loop state clears. In high mode it supplies a predicted predicate equal to the predicted direction. In low mode it uses the predictor's direction with no predicate prediction.
- R9: A resolved wish-loop misprediction flushes in high mode. In low mode it flushes on an early exit (actual outcome taken) and on a no-exit case (actual outcome not taken, while the front end has not yet fetched a not-taken instance of the loop). It does not flush on a late exit (actual outcome not taken after the front end has already exited).
- R10: Region state clears on a resolve of a jump or join with `resolveLast` set, and on any flush. Loop state clears on a resolve of the loop with actual outcome not taken, and on any flush.
- R11: All outputs are registered. Results appear in the cycle after a valid fetch or resolve. Every fetch output is 0 in a cycle that follows no fetch.
- R12: When a flush is raised in the same cycle as a fetch, the fetch's result is still reported, but its effect on region and loop state is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A branch is fetched this cycle |
| fetchHint | input | 2 | Hint class of the fetched branch |
| predTaken | input | 1 | Predictor direction for the fetched branch |
| predConf | input | 1 | Confidence of that prediction, 1 = high |
| resolveValid | input | 1 | A branch resolves this cycle |
| resolveHint | input | 2 | Hint class of the resolving branch |
| resolveMispred | input | 1 | The resolving branch was mispredicted |
| resolveTaken | input | 1 | Actual outcome of the resolving branch |
| resolveLast | input | 1 | The resolving jump or join ends its region |
| outValid | output | 1 | Fetch result valid |
| outTaken | output | 1 | Final predicted direction |
| outPredValid | output | 1 | A predicate value is predicted |
| outPredVal | output | 1 | Predicted predicate value |
| outModeLow | output | 1 | Branch handled in low-confidence mode |
| flushReq | output | 1 | Pipeline flush request |

## Verification
The hardest situations to reach are those that depend on history inside a region or a loop: a join forced taken by an earlier high-confidence not-taken jump, low confidence made sticky by a middle join, and the split between late-exit and no-exit loop mispredictions, which hinges on whether a not-taken loop instance was already fetched. The bench sweeps every combination of direction and confidence over a jump followed by two joins. It replays loop fetch sequences that do and do not leave the loop before the resolve, and it fires flushes both alone and alongside fetches so that state clearing becomes visible through the next fetched join or loop.

// File: rtl/wishModePkg.sv
package wishModePkg;

  localparam int HINT_W = 2;

  typedef enum logic [HINT_W-1:0] {
    KIND_NORMAL = 2'd0,
    KIND_JUMP   = 2'd1,
    KIND_JOIN   = 2'd2,
    KIND_LOOP   = 2'd3
  } branchKind_e;

  typedef enum logic [1:0] {
    DIR_PRED = 2'd0,
    DIR_ZERO = 2'd1,
    DIR_ONE  = 2'd2
  } dirSel_e;

  typedef struct packed {
    dirSel_e dirSel;
    logic    predEn;
    logic    modeLow;
    logic    flush;
  } ctlStrobe_t;

endpackage

// File: rtl/wishModeCtrl.sv
module wishModeCtrl
  import wishModePkg::*;
#(
  parameter int HW = HINT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fetchValid,
  input  logic [HW-1:0] fetchHint,
  input  logic          predTaken,
  input  logic          predConf,
  input  logic          resolveValid,
  input  logic [HW-1:0] resolveHint,
  input  logic          resolveMispred,
  input  logic          resolveTaken,
  input  logic          resolveLast,
  output ctlStrobe_t    strobe
);

  branchKind_e fetchKind, resolveKind;
  assign fetchKind   = branchKind_e'(fetchHint);
  assign resolveKind = branchKind_e'(resolveHint);

  // region state
  logic regionActQ, regionLowQ, forceJoinQ;
  logic regionActD, regionLowD, forceJoinD;
  // loop state
  logic loopActQ, loopLowQ, loopExitedQ;
  logic loopActD, loopLowD, loopExitedD;

  logic joinLowNow, loopLowNow, flushNow;

  assign joinLowNow = regionLowQ | ~predConf;
  assign loopLowNow = loopActQ ? loopLowQ : ~predConf;

  // fetch-side decision strobes
  always_comb begin
    strobe.dirSel  = DIR_PRED;
    strobe.predEn  = 1'b0;
    strobe.modeLow = 1'b0;
    case (fetchKind)
      KIND_JUMP: begin
        if (predConf) begin
          strobe.predEn = 1'b1;
        end else begin
          strobe.dirSel  = DIR_ZERO;
          strobe.modeLow = 1'b1;
        end
      end
      KIND_JOIN: begin
        if (joinLowNow) begin
          strobe.dirSel  = DIR_ZERO;
          strobe.modeLow = 1'b1;
        end else if (forceJoinQ) begin
          strobe.dirSel = DIR_ONE;
        end
      end
      KIND_LOOP: begin
        strobe.modeLow = loopLowNow;
        strobe.predEn  = ~loopLowNow;
      end
      default: ;
    endcase
    strobe.flush = flushNow;
  end

  // resolve-side flush decision
  always_comb begin
    flushNow = 1'b0;
    if (resolveValid && resolveMispred) begin
      case (resolveKind)
        KIND_NORMAL: flushNow = 1'b1;
        KIND_JUMP,
        KIND_JOIN:   flushNow = ~regionLowQ;
        KIND_LOOP:   flushNow = ~loopLowQ | resolveTaken | ~loopExitedQ;
        default:     flushNow = 1'b0;
      endcase
    end
  end

  // next state: resolve clears first, a fetch then overrides, a flush wipes all
  always_comb begin
    regionActD  = regionActQ;
    regionLowD  = regionLowQ;
    forceJoinD  = forceJoinQ;
    loopActD    = loopActQ;
    loopLowD    = loopLowQ;
    loopExitedD = loopExitedQ;

    if (resolveValid && resolveLast &&
        (resolveKind == KIND_JUMP || resolveKind == KIND_JOIN)) begin
      regionActD = 1'b0;
      regionLowD = 1'b0;
      forceJoinD = 1'b0;
    end
    if (resolveValid && resolveKind == KIND_LOOP && !resolveTaken) begin
      loopActD    = 1'b0;
      loopLowD    = 1'b0;
      loopExitedD = 1'b0;
    end

    if (fetchValid) begin
      case (fetchKind)
        KIND_JUMP: begin
          regionActD = 1'b1;
          regionLowD = ~predConf;
          forceJoinD = predConf & ~predTaken;
        end
        KIND_JOIN: begin
          regionActD = 1'b1;
          regionLowD = joinLowNow;
          forceJoinD = 1'b0;
        end
        KIND_LOOP: begin
          loopActD = 1'b1;
          loopLowD = loopLowNow;
          if (!predTaken) loopExitedD = 1'b1;
        end
        default: ;
      endcase
    end

    if (flushNow) begin
      regionActD  = 1'b0;
      regionLowD  = 1'b0;
      forceJoinD  = 1'b0;
      loopActD    = 1'b0;
      loopLowD    = 1'b0;
      loopExitedD = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regionActQ  <= 1'b0;
      regionLowQ  <= 1'b0;
      forceJoinQ  <= 1'b0;
      loopActQ    <= 1'b0;
      loopLowQ    <= 1'b0;
      loopExitedQ <= 1'b0;
    end else begin
      regionActQ  <= regionActD;
      regionLowQ  <= regionLowD;
      forceJoinQ  <= forceJoinD;
      loopActQ    <= loopActD;
      loopLowQ    <= loopLowD;
      loopExitedQ <= loopExitedD;
    end
  end

  // R5: low confidence in a region survives a later join fetch
  a_r5_sticky_low: assert property (@(posedge clk) disable iff (!rstN)
    (regionLowQ && fetchValid && fetchKind == KIND_JOIN && !flushNow)
      |=> regionLowQ);

  // R4: a forced-taken join consumes the force
  a_r4_force_once: assert property (@(posedge clk) disable iff (!rstN)
    (forceJoinQ && fetchValid && fetchKind == KIND_JOIN)
      |=> !forceJoinQ);

  // R10: a flush leaves no region or loop state behind
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flushNow |=> (!regionActQ && !regionLowQ && !loopActQ));

endmodule

// File: rtl/wishModeData.sv
module wishModeData
  import wishModePkg::*;
#(
  parameter int HW = HINT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fetchValid,
  input  logic [HW-1:0] fetchHint,
  input  logic          predTaken,
  input  logic          predConf,
  input  logic          resolveValid,
  input  logic          resolveMispred,
  input  ctlStrobe_t    strobe,
  output logic          outValid,
  output logic          outTaken,
  output logic          outPredValid,
  output logic          outPredVal,
  output logic          outModeLow,
  output logic          flushReq
);

  logic dirBit;

  always_comb begin
    case (strobe.dirSel)
      DIR_ZERO: dirBit = 1'b0;
      DIR_ONE:  dirBit = 1'b1;
      default:  dirBit = predTaken;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outTaken     <= 1'b0;
      outPredValid <= 1'b0;
      outPredVal   <= 1'b0;
      outModeLow   <= 1'b0;
      flushReq     <= 1'b0;
    end else begin
      outValid     <= fetchValid;
      outTaken     <= fetchValid & dirBit;
      outPredValid <= fetchValid & strobe.predEn;
      outPredVal   <= fetchValid & strobe.predEn & predTaken;
      outModeLow   <= fetchValid & strobe.modeLow;
      flushReq     <= strobe.flush;
    end
  end

  // R1: normal branches pass the predictor through untouched
  a_r1_normal_pass: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchHint == KIND_NORMAL)
      |=> (outTaken == $past(predTaken) && !outPredValid && !outModeLow));

  // R3: low-confidence jump steers to fall-through without predicate
  a_r3_low_jump: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchHint == KIND_JUMP && !predConf)
      |=> (outModeLow && !outTaken && !outPredValid));

  // R6: flush only follows a resolved misprediction
  a_r6_flush_cause: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> $past(resolveValid && resolveMispred));

  // R11: no fetch result without a fetch
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> (!outValid && !outTaken && !outPredValid && !outModeLow));

  // R8: low mode never carries a predicate prediction
  a_r8_low_no_pred: assert property (@(posedge clk) disable iff (!rstN)
    outModeLow |-> !outPredValid);

endmodule

// File: rtl/wishModeCtl.sv
module wishModeCtl
  import wishModePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchValid,
  input  logic [1:0] fetchHint,
  input  logic       predTaken,
  input  logic       predConf,
  input  logic       resolveValid,
  input  logic [1:0] resolveHint,
  input  logic       resolveMispred,
  input  logic       resolveTaken,
  input  logic       resolveLast,
  output logic       outValid,
  output logic       outTaken,
  output logic       outPredValid,
  output logic       outPredVal,
  output logic       outModeLow,
  output logic       flushReq
);

  ctlStrobe_t strobe;

  wishModeCtrl #(.HW(HINT_W)) ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .fetchValid     (fetchValid),
    .fetchHint      (fetchHint),
    .predTaken      (predTaken),
    .predConf       (predConf),
    .resolveValid   (resolveValid),
    .resolveHint    (resolveHint),
    .resolveMispred (resolveMispred),
    .resolveTaken   (resolveTaken),
    .resolveLast    (resolveLast),
    .strobe         (strobe)
  );

  wishModeData #(.HW(HINT_W)) data_i (
    .clk            (clk),
    .rstN           (rstN),
    .fetchValid     (fetchValid),
    .fetchHint      (fetchHint),
    .predTaken      (predTaken),
    .predConf       (predConf),
    .resolveValid   (resolveValid),
    .resolveMispred (resolveMispred),
    .strobe         (strobe),
    .outValid       (outValid),
    .outTaken       (outTaken),
    .outPredValid   (outPredValid),
    .outPredVal     (outPredVal),
    .outModeLow     (outModeLow),
    .flushReq       (flushReq)
  );

endmodule

// File: tb/wishModeCtl_tb.sv
module wishModeCtl_tb_top;

  logic clk = 1'b0;
  logic rstN;
  logic fetchValid, predTaken, predConf;
  logic [1:0] fetchHint, resolveHint;
  logic resolveValid, resolveMispred, resolveTaken, resolveLast;
  logic outValid, outTaken, outPredValid, outPredVal, outModeLow, flushReq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  wishModeCtl dut_i (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchHint(fetchHint),
    .predTaken(predTaken), .predConf(predConf),
    .resolveValid(resolveValid), .resolveHint(resolveHint),
    .resolveMispred(resolveMispred), .resolveTaken(resolveTaken),
    .resolveLast(resolveLast),
    .outValid(outValid), .outTaken(outTaken), .outPredValid(outPredValid),
    .outPredVal(outPredVal), .outModeLow(outModeLow), .flushReq(flushReq)
  );

  localparam logic [1:0] H_NORM = 2'd0, H_JUMP = 2'd1, H_JOIN = 2'd2, H_LOOP = 2'd3;

  task automatic check(string req, string what, logic [4:0] act, logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] pack();
    return {outValid, outTaken, outPredValid, outPredVal, outModeLow};
  endfunction

  function automatic logic [4:0] expv(logic t, logic pv, logic p, logic m);
    return {1'b1, t, pv, p, m};
  endfunction

  task automatic idleInputs();
    fetchValid = 0; fetchHint = 0; predTaken = 0; predConf = 0;
    resolveValid = 0; resolveHint = 0; resolveMispred = 0;
    resolveTaken = 0; resolveLast = 0;
  endtask

  // drive at negedge, sample at the following negedge
  task automatic fetch(logic [1:0] h, logic t, logic c);
    fetchValid = 1; fetchHint = h; predTaken = t; predConf = c;
    @(posedge clk); @(negedge clk);
    idleInputs();
  endtask

  task automatic resolve(logic [1:0] h, logic mp, logic at, logic last);
    resolveValid = 1; resolveHint = h; resolveMispred = mp;
    resolveTaken = at; resolveLast = last;
    @(posedge clk); @(negedge clk);
    idleInputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idleInputs();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R11 reset state
    check("R11", "reset outputs", pack(), 5'b0);
    check("R11", "reset flush", {4'b0, flushReq}, 5'b0);

    // R1 normal branch sweep
    for (int t = 0; t < 2; t++)
      for (int c = 0; c < 2; c++) begin
        fetch(H_NORM, t[0], c[0]);
        check("R1", "normal", pack(), expv(t[0], 0, 0, 0));
      end
    // R11 idle cycle after fetch
    @(posedge clk); @(negedge clk);
    check("R11", "idle", pack(), 5'b0);

    // R2-R5 sweep: jump then two joins, all direction/confidence combinations
    for (int s = 0; s < 64; s++) begin
      logic tj, cj, t1, c1, t2, c2, low, force_;
      {tj, cj, t1, c1, t2, c2} = s[5:0];
      fetch(H_JUMP, tj, cj);
      if (cj) check("R2", "jump high", pack(), expv(tj, 1, tj, 0));
      else    check("R3", "jump low",  pack(), expv(0, 0, 0, 1));
      low = ~cj;
      force_ = cj & ~tj;
      fetch(H_JOIN, t1, c1);
      low = low | ~c1;
      if (low)        check("R5", "join1 low", pack(), expv(0, 0, 0, 1));
      else if (force_) check("R4", "join1 forced", pack(), expv(1, 0, 0, 0));
      else            check("R5", "join1 pred", pack(), expv(t1, 0, 0, 0));
      fetch(H_JOIN, t2, c2);
      low = low | ~c2;
      if (low) check("R5", "join2 low", pack(), expv(0, 0, 0, 1));
      else     check("R4", "join2 unforced", pack(), expv(t2, 0, 0, 0));
      resolve(H_JOIN, 0, 0, 1);
      check("R10", "no flush on correct resolve", {4'b0, flushReq}, 5'b0);
    end

    // R6 jump/join misprediction flush by region mode
    for (int s = 0; s < 4; s++) begin
      logic cj, c1;
      {cj, c1} = s[1:0];
      fetch(H_JUMP, 1, cj);
      fetch(H_JOIN, 1, c1);
      resolve(H_JUMP, 1, 0, 0);
      check("R6", "wish mispredict flush", {4'b0, flushReq}, {4'b0, cj & c1});
      if (!(cj & c1)) begin
        resolve(H_JOIN, 0, 0, 1);
      end
    end

    // R7 normal mispredict flush; R10 flush clears a pending forced join
    fetch(H_JUMP, 0, 1);
    resolve(H_NORM, 1, 1, 0);
    check("R7", "normal mispredict flush", {4'b0, flushReq}, 5'b1);
    fetch(H_JOIN, 0, 1);
    check("R10", "force cleared by flush", pack(), expv(0, 0, 0, 0));
    resolve(H_JOIN, 0, 0, 1);

    // R10 resolveLast clears sticky low
    fetch(H_JUMP, 1, 0);
    resolve(H_JUMP, 0, 0, 1);
    fetch(H_JOIN, 1, 1);
    check("R10", "low cleared by last", pack(), expv(1, 0, 0, 0));
    resolve(H_JOIN, 0, 0, 1);

    // R8 loop high mode: predicate follows direction; mode held despite low conf later
    fetch(H_LOOP, 1, 1);
    check("R8", "loop high taken", pack(), expv(1, 1, 1, 0));
    fetch(H_LOOP, 1, 0);
    check("R8", "loop stays high", pack(), expv(1, 1, 1, 0));
    fetch(H_LOOP, 0, 0);
    check("R8", "loop high exit", pack(), expv(0, 1, 0, 0));
    resolve(H_LOOP, 1, 0, 0);
    check("R9", "loop high mispredict", {4'b0, flushReq}, 5'b1);

    // R8 low loop, R9 late exit: no flush
    fetch(H_LOOP, 1, 0);
    check("R8", "loop low", pack(), expv(1, 0, 0, 1));
    fetch(H_LOOP, 1, 1);
    check("R8", "loop stays low", pack(), expv(1, 0, 0, 1));
    fetch(H_LOOP, 0, 1);
    check("R8", "loop low exit", pack(), expv(0, 0, 0, 1));
    resolve(H_LOOP, 1, 0, 0);
    check("R9", "late exit no flush", {4'b0, flushReq}, 5'b0);
    // R10 loop cleared by not-taken resolve: new loop enters high
    fetch(H_LOOP, 1, 1);
    check("R10", "loop re-entered high", pack(), expv(1, 1, 1, 0));
    resolve(H_LOOP, 0, 0, 0);

    // R9 no exit: low loop, still iterating
    fetch(H_LOOP, 1, 0);
    fetch(H_LOOP, 1, 0);
    resolve(H_LOOP, 1, 0, 0);
    check("R9", "no exit flush", {4'b0, flushReq}, 5'b1);

    // R9 early exit: low loop, actual taken
    fetch(H_LOOP, 0, 0);
    resolve(H_LOOP, 1, 1, 0);
    check("R9", "early exit flush", {4'b0, flushReq}, 5'b1);

    // R12 flush in the same cycle as a jump fetch drops the jump's state
    fetchValid = 1; fetchHint = H_JUMP; predTaken = 1; predConf = 0;
    resolveValid = 1; resolveHint = H_NORM; resolveMispred = 1;
    @(posedge clk); @(negedge clk);
    idleInputs();
    check("R12", "fetch result still reported", pack(), expv(0, 0, 0, 1));
    check("R12", "flush raised", {4'b0, flushReq}, 5'b1);
    fetch(H_JOIN, 1, 1);
    check("R12", "jump state dropped", pack(), expv(1, 0, 0, 0));
    resolve(H_JOIN, 0, 0, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule